// File: doc/BRIEF.md
# Multi-link Transmit SYNC Controller

This block runs the link bring-up sequence for a transmitter that feeds several converter links which must start together. Each link returns an active-low SYNC line: a low level asks the transmitter to send code-group synchronisation characters, and a high level releases it. Each line goes through a two-flop synchroniser. A runtime-writable disable mask then forces selected links to read as released. The remaining lines are merged into one combined request, which is high when any enabled link holds SYNC low.

The combined request drives a three-state sequencer. The states are code-group synchronisation, initial lane alignment and user data. Alignment lasts a fixed number of multiframes. A request seen in alignment or data sends the sequencer back to synchronisation on the next clock. Software sets the disable mask through a small word-addressed register port. The same port returns the synchronised SYNC levels before masking, so the real pin state of a disabled converter can still be seen.

Top module: `txsync_multilink_ctrl`

## Requirements
- R1: After reset the sequencer is in synchronisation (`link_state` = 0). The disable mask reads 0, the status reads 0 and `sync_req` is 1.
- R2: A change on `sync_n_in[i]` appears in the status register after exactly two rising clock edges, and not after one.
- R3: The status register (word address 0x0C0, bit i = link i) returns the synchronised SYNC levels without the disable mask applied.
- R4: A link whose disable bit is 1 counts as SYNC high, whatever level its pin has.
- R5: While any enabled link has a synchronised SYNC low, `sync_req` is 1 and the sequencer stays in synchronisation (state 0).
- R6: When `sync_req` is 0 in synchronisation, the sequencer enters alignment (state 1) on the next edge. It stays there for ILA_MF*MF_CYCLES cycles (default 4*8 = 32) and then enters data (state 2).
- R7: If `sync_req` is 1 while the sequencer is in alignment or data, it returns to state 0 on the next edge.
- R8: When every link is disabled, `sync_req` is 0 whatever the pin levels are.
- R9: While `en` is low, the sequencer is held in state 0 and the alignment count restarts.
- R10: The disable mask is written and read at word address 0x081, with bit i = link i. Bits at and above NUM_LINKS read 0, and any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Global enable; low holds the sequencer in synchronisation |
| sync_n_in | input | NUM_LINKS | Active-low SYNC line per link |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| sync_req | output | 1 | Combined request; 1 when any enabled link holds SYNC low |
| link_state | output | 2 | 0 synchronisation, 1 alignment, 2 data |

## Verification
Two events can land on the same edge. One is a write to the disable mask. The other is a SYNC edge leaving the second synchroniser flop. They can either cancel each other in the combined request or add up in it. The stimulus flips pins at random and writes the mask at random on the same cycles, so these collisions happen many times. Directed cases also disable a link while it is being pulled low. Each cycle, a bench-side model built from the requirements predicts `sync_req`, `link_state` and the value read back. The outputs are compared with it between edges.

// File: rtl/txsync_pkg.sv
package txsync_pkg;

    typedef enum logic [1:0] {
        ST_CGS  = 2'd0,
        ST_ILA  = 2'd1,
        ST_DATA = 2'd2
    } link_state_t;

    localparam int REG_DW = 32;

    localparam logic [11:0] REG_LINK_DIS  = 12'h081;
    localparam logic [11:0] REG_SYNC_STAT = 12'h0C0;

    typedef struct packed {
        logic [REG_DW-1:0] dis;
        logic [REG_DW-1:0] lvl;
    } link_view_t;

    // High when any link that is not disabled sees SYNC low.
    function automatic logic any_enabled_low(link_view_t v, int n);
        logic r;
        r = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (!v.dis[i] && !v.lvl[i]) r = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/txsync_bit_sync.sv
module txsync_bit_sync (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= 1'b0;
            q_sync <= 1'b0;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/txsync_regs.sv
module txsync_regs #(
    parameter int NUM_LINKS = 4,
    parameter int ADDR_W    = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [31:0]          wdata,
    input  logic [NUM_LINKS-1:0] sync_lvl,
    output logic [NUM_LINKS-1:0] link_dis,
    output logic [31:0]          rdata
);
    import txsync_pkg::*;

    localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(REG_LINK_DIS);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_SYNC_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            link_dis <= '0;
        end else if (wr_en && addr == A_DIS) begin
            link_dis <= wdata[NUM_LINKS-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_DIS)       rdata[NUM_LINKS-1:0] = link_dis;
        else if (addr == A_STAT) rdata[NUM_LINKS-1:0] = sync_lvl;
    end

    a_r10_write_lands: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_DIS) |=> (link_dis == $past(wdata[NUM_LINKS-1:0])));
endmodule

// File: rtl/txsync_fsm.sv
module txsync_fsm #(
    parameter int ILA_MF    = 4,
    parameter int MF_CYCLES = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic                   req,
    output txsync_pkg::link_state_t state
);
    import txsync_pkg::*;

    localparam int ILA_LEN = ILA_MF * MF_CYCLES;
    localparam int CNT_W   = (ILA_LEN > 1) ? $clog2(ILA_LEN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ILA_LEN - 1);

    logic [CNT_W-1:0] ila_cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state   <= ST_CGS;
            ila_cnt <= '0;
        end else begin
            unique case (state)
                ST_CGS: begin
                    ila_cnt <= '0;
                    if (!req) state <= ST_ILA;
                end
                ST_ILA: begin
                    if (req) begin
                        state   <= ST_CGS;
                        ila_cnt <= '0;
                    end else if (ila_cnt == CNT_LAST) begin
                        state   <= ST_DATA;
                        ila_cnt <= '0;
                    end else begin
                        ila_cnt <= ila_cnt + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (req) state <= ST_CGS;
                end
                default: state <= ST_CGS;
            endcase
        end
    end

    a_r5_hold_cgs: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CGS && req) |=> (state == ST_CGS));
    a_r7_fall_back: assert property (@(posedge clk) disable iff (rst)
        (state != ST_CGS && req) |=> (state == ST_CGS));
    a_r9_enable_hold: assert property (@(posedge clk) disable iff (rst)
        (!en) |=> (state == ST_CGS));
    a_r6_data_via_ila: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && $past(state) != ST_DATA) |-> ($past(state) == ST_ILA));
endmodule

// File: rtl/txsync_multilink_ctrl.sv
module txsync_multilink_ctrl #(
    parameter int NUM_LINKS = 4,
    parameter int ADDR_W    = 12,
    parameter int ILA_MF    = 4,
    parameter int MF_CYCLES = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [NUM_LINKS-1:0] sync_n_in,
    input  logic                 reg_wr_en,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic                 sync_req,
    output logic [1:0]           link_state
);
    import txsync_pkg::*;

    logic [NUM_LINKS-1:0] sync_lvl;
    logic [NUM_LINKS-1:0] link_dis;
    link_view_t           view;
    link_state_t          st;

    for (genvar g = 0; g < NUM_LINKS; g++) begin : g_sync
        txsync_bit_sync u_bs (
            .clk     (clk),
            .rst     (rst),
            .d_async (sync_n_in[g]),
            .q_sync  (sync_lvl[g])
        );
    end

    txsync_regs #(.NUM_LINKS(NUM_LINKS), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .sync_lvl (sync_lvl),
        .link_dis (link_dis),
        .rdata    (reg_rdata)
    );

    always_comb begin
        view = '0;
        view.dis[NUM_LINKS-1:0] = link_dis;
        view.lvl[NUM_LINKS-1:0] = sync_lvl;
        sync_req = any_enabled_low(view, NUM_LINKS);
    end

    txsync_fsm #(.ILA_MF(ILA_MF), .MF_CYCLES(MF_CYCLES)) u_fsm (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .req   (sync_req),
        .state (st)
    );

    assign link_state = st;

    a_r8_all_disabled: assert property (@(posedge clk) disable iff (rst)
        (&link_dis) |-> !sync_req);
    a_r4_masked_ignored: assert property (@(posedge clk) disable iff (rst)
        ((sync_lvl | link_dis) == {NUM_LINKS{1'b1}}) |-> !sync_req);
endmodule

// File: tb/txsync_multilink_ctrl_test.sv
`timescale 1ns/1ps
module txsync_multilink_ctrl_test;
    localparam int NL  = 4;
    localparam int AW  = 12;
    localparam int ILA = 4 * 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b1;
    logic [NL-1:0] sync_n_in = '0;
    logic          reg_wr_en = 1'b0;
    logic [AW-1:0] reg_addr  = 12'h0C0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          sync_req;
    logic [1:0]    link_state;

    int checks = 0;
    int fails  = 0;

    // bench-side model
    logic [NL-1:0] m_s1 = '0, m_s2 = '0, m_dis = '0;
    int            m_state = 0;
    int            m_cnt = 0;

    always #2.5 clk = ~clk;

    txsync_multilink_ctrl uut (
        .clk(clk), .rst(rst), .en(en), .sync_n_in(sync_n_in),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sync_req(sync_req), .link_state(link_state)
    );

    function automatic logic exp_req(logic [NL-1:0] lvl, logic [NL-1:0] dis);
        return |(~lvl & ~dis);
    endfunction

    function automatic logic [31:0] exp_rd(logic [AW-1:0] a);
        logic [31:0] r;
        r = '0;
        if (a == 12'h081) r[NL-1:0] = m_dis;
        else if (a == 12'h0C0) r[NL-1:0] = m_s2;
        return r;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // one clock: update model from pre-edge inputs, then compare at negedge
    task automatic tick(string tag);
        logic r;
        @(posedge clk);
        r = exp_req(m_s2, m_dis);
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_dis = '0; m_state = 0; m_cnt = 0;
        end else begin
            if (!en) begin
                m_state = 0; m_cnt = 0;
            end else if (m_state == 0) begin
                m_cnt = 0;
                if (!r) m_state = 1;
            end else if (m_state == 1) begin
                if (r) begin m_state = 0; m_cnt = 0; end
                else if (m_cnt == ILA - 1) begin m_state = 2; m_cnt = 0; end
                else m_cnt++;
            end else if (r) m_state = 0;
            m_s2 = m_s1;
            m_s1 = sync_n_in;
            if (reg_wr_en && reg_addr == 12'h081) m_dis = reg_wdata[NL-1:0];
        end
        @(negedge clk);
        check({tag, " R5 sync_req"}, 32'(sync_req), 32'(exp_req(m_s2, m_dis)));
        check({tag, " R6 state"}, 32'(link_state), 32'(m_state));
        check({tag, " R10 rdata"}, reg_rdata, exp_rd(reg_addr));
    endtask

    task automatic wr_dis(logic [31:0] v);
        reg_wr_en = 1'b1; reg_addr = 12'h081; reg_wdata = v;
        tick("R10 write");
        reg_wr_en = 1'b0; reg_addr = 12'h0C0;
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd24680));
        tick("R1 reset");
        tick("R1 reset");
        rst = 1'b0;
        @(negedge clk);
        check("R1 state", 32'(link_state), 0);
        check("R1 sync_req", 32'(sync_req), 1);
        check("R1 status", reg_rdata, 0);
        reg_addr = 12'h081;
        #0.1 check("R1 dis", reg_rdata, 0);
        reg_addr = 12'h0C0;

        // R2: latency of two edges
        sync_n_in = '1;
        tick("R2");
        check("R2 one edge", reg_rdata, 0);
        tick("R2");
        check("R2 two edges", reg_rdata, 32'hF);
        tick("R6 entry");
        check("R6 enter ila", 32'(link_state), 1);
        for (int i = 0; i < ILA - 1; i++) tick("R6 ila");
        check("R6 still ila", 32'(link_state), 1);
        tick("R6 data");
        check("R6 data", 32'(link_state), 2);

        // R7: drop link 1 in data
        sync_n_in[1] = 1'b0;
        tick("R7"); tick("R7");
        check("R7 req up", 32'(sync_req), 1);
        tick("R7");
        check("R7 back cgs", 32'(link_state), 0);

        // R4/R3: disable link 1 while it is held low
        wr_dis(32'hFFFF_FFF2);
        check("R4 masked req", 32'(sync_req), 0);
        check("R10 upper zero", 32'(exp_rd(12'h081)), 32'h2);
        reg_addr = 12'h081;
        #0.1 check("R10 readback", reg_rdata, 32'h2);
        reg_addr = 12'h0C0;
        #0.1 check("R3 raw status", reg_rdata, 32'hD);
        reg_addr = 12'h155;
        #0.1 check("R10 other addr", reg_rdata, 0);
        reg_addr = 12'h0C0;
        tick("R4");
        check("R4 leaves cgs", 32'(link_state), 1);

        // R8: all disabled, all pins low
        sync_n_in = '0;
        wr_dis(32'hF);
        tick("R8"); tick("R8");
        check("R8 no req", 32'(sync_req), 0);
        check("R3 raw low", reg_rdata, 0);

        // R9: enable low
        en = 1'b0;
        tick("R9"); tick("R9");
        check("R9 held", 32'(link_state), 0);
        en = 1'b1;
        wr_dis(32'h0);
        sync_n_in = '1;

        // random phase: pins, mask writes and enable collide
        for (int c = 0; c < 6000; c++) begin
            for (int i = 0; i < NL; i++)
                if ($urandom_range(0, 15) == 0) sync_n_in[i] = ~sync_n_in[i];
            en = ($urandom_range(0, 199) != 0);
            if ($urandom_range(0, 19) == 0) begin
                reg_wr_en = 1'b1; reg_addr = 12'h081;
                reg_wdata = ($urandom_range(0, 1) == 0) ? 32'h0 : $urandom;
            end else begin
                reg_wr_en = 1'b0;
                case ($urandom_range(0, 2))
                    0: reg_addr = 12'h081;
                    1: reg_addr = 12'h0C0;
                    default: reg_addr = AW'($urandom);
                endcase
                if ($urandom_range(0, 3) != 0) sync_n_in = sync_n_in | 4'(($urandom_range(0,3)==0) ? 4'hF : 4'h0);
            end
            tick("R5/R7 random");
        end
        reg_wr_en = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule